// File: doc/BRIEF.md
# Network Controller Interrupt Aggregator

This block gathers the event sources of a small Ethernet controller into one flag register and turns them into a single active-low interrupt request for a host processor. Four of the flags are sticky and can be set and cleared by the host: receive error, transmit error, transmit done and DMA done. Two are read-only. The packet-pending flag follows a packet count supplied from outside. The link-change flag mirrors a gated PHY-side flag.

The host writes through one strobe, an operation code and a data byte. It can load the enable register, set or clear flag bits by mask, or load the two PHY-side interrupt enables. A combinational read port returns the flag, enable, status or PHY flag register, chosen by a select input. Transmit done and DMA done are raised from falling edges of the transmit-request and DMA-busy levels. A PHY flag read strobe clears the PHY-side flags together with the mirrored link bit.

Top module: `nic_irq_hub`

## Requirements
- R1: Reset clears the flags, both enable registers and the PHY flags, and drives `irq_n` high. Flag bits 0 (receive error), 1 (transmit error), 2 (transmit done) and 4 (DMA done) are sticky. A set bit stays set until a host clear or a reset. Host operation 1 sets the flag bits selected by `host_data`, and operation 2 clears them.
- R2: Enable register layout: bits 0 to 5 enable the flag of the same position, and bit 7 is the global enable. It is written with host operation 0. `irq_n` is low in the cycle after an edge at which some flag bit, its enable bit and the global enable were all 1. Otherwise `irq_n` is high.
- R3: Flag bit 5 (packet pending) is 1 exactly while `pkt_cnt` is non-zero, with no register in the path. Host set and clear operations do not change it.
- R4: A 1-to-0 transition of `tx_req` sets flag bit 2 at the first edge that samples `tx_req` low.
- R5: Whenever flag bit 1 becomes set, flag bit 2 becomes set at the same edge. This holds both for a `tx_err_evt` pulse and for a host set of bit 1.
- R6: A 1-to-0 transition of `dma_busy` sets flag bit 4 at the first edge that samples `dma_busy` low.
- R7: PHY enable register layout, written with host operation 3: bit 0 is the link enable and bit 1 is the PHY global enable. On `link_evt`, the PHY link flag (PHY flag register bit 0) always sets. The PHY global flag (bit 1) sets only while the link enable is 1. Flag bit 3 reads as the PHY global flag ANDed with both PHY enables, and is otherwise 0. Host set and clear operations do not change it.
- R8: A `phy_flag_rd` strobe clears the PHY link flag and the PHY global flag at the next edge, so flag bit 3 reads 0 afterwards.
- R9: The link change drives `irq_n` low only while all four enables are 1: enable bit 3, enable bit 7 and both PHY enables. Clearing any one of them returns `irq_n` high one cycle later.
- R10: When an event and a host clear hit the same sticky flag at the same edge, the flag ends set.
- R11: Status register bit 0 reads 1 exactly while `irq_n` is low. The other status bits read 0.
- R12: `rd_sel` selects the read register combinationally: 0 selects flags, 1 enables, 2 status and 3 PHY flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_err_evt | input | 1 | Receive error event pulse |
| tx_err_evt | input | 1 | Transmit abort event pulse |
| tx_req | input | 1 | Transmit-request level; a falling edge means the transmission ended |
| dma_busy | input | 1 | DMA-start level; a falling edge means the DMA ended or was cancelled |
| link_evt | input | 1 | PHY link status change pulse |
| pkt_cnt | input | CNT_W | Number of packets held in the receive buffer |
| host_wr | input | 1 | Host write strobe |
| host_op | input | 2 | 0 enable write, 1 flag set, 2 flag clear, 3 PHY enable write |
| host_data | input | 8 | Host write data or mask |
| phy_flag_rd | input | 1 | Strobe marking a read of the PHY flag register |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 8 | Selected register contents |
| irq_n | output | 1 | Interrupt request, active low, registered |

## Verification
Flag bits driven by events, by host set and clear operations, or by falling edges of the level inputs show up on `rd_data` one edge after the stimulus. The packet-pending bit and the mirrored link bit respond to `pkt_cnt` and the enable registers through combinational logic only. `irq_n` follows one edge after the flags and enables it is derived from. The bench drives every input just after a falling clock edge. It reads flags at the next falling edge and `irq_n` one further falling edge later. It checks combinational reads one time unit after the input changes, never at a rising edge.

// File: rtl/nic_irq_pkg.sv
// Shared constants and codes for the interrupt aggregator.
// Assumes an 8-bit host data path.
package nic_irq_pkg;
    localparam int REG_W    = 8;
    localparam int B_RXERR  = 0;
    localparam int B_TXERR  = 1;
    localparam int B_TXDONE = 2;
    localparam int B_LINK   = 3;
    localparam int B_DMA    = 4;
    localparam int B_PKT    = 5;
    localparam int B_GLBEN  = 7;
    localparam int N_STICKY = 4;   // rx err, tx err, tx done, dma done

    typedef enum logic [1:0] {
        OP_EN_WR     = 2'd0,
        OP_FLAG_SET  = 2'd1,
        OP_FLAG_CLR  = 2'd2,
        OP_PHY_EN_WR = 2'd3
    } host_op_e;

    typedef enum logic [1:0] {
        RD_FLAGS     = 2'd0,
        RD_ENABLES   = 2'd1,
        RD_STATUS    = 2'd2,
        RD_PHY_FLAGS = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/nic_irq_fall.sv
// Falling-edge detector for a vector of level inputs.
// Assumes the inputs are synchronous to clk. The previous value resets to 0,
// so no edge is reported in the first cycle after reset.
module nic_irq_fall #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] fell
);
    logic [N-1:0] prev_q;

    // Hold last cycle's level of each input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    // A 1 -> 0 change is seen when the held value is 1 and the input is 0.
    always_comb fell = prev_q & ~lvl;
endmodule

// File: rtl/nic_irq_sticky.sv
// Bank of sticky flag bits with event set, host set and host clear.
// Any set source wins over a clear in the same cycle.
// Assumes single-cycle set and clear pulses.
module nic_irq_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_set,
    input  logic [N-1:0] host_set,
    input  logic [N-1:0] host_clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic q_r;

        // Update one flag: set wins, otherwise clear, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n)                       q_r <= 1'b0;
            else if (evt_set[i] || host_set[i]) q_r <= 1'b1;
            else if (host_clr[i])             q_r <= 1'b0;
        end

        assign q[i] = q_r;

        // R1: a set flag stays set unless a clear arrives.
        assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (q_r && !host_clr[i]) |=> q_r);

        // R10: an event beats a simultaneous clear.
        assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_set[i] && host_clr[i]) |=> q_r);
    end
endmodule

// File: rtl/nic_irq_phy.sv
// Two-level PHY-side interrupt path feeding the read-only link-change flag.
// The link flag always records link events. The PHY global flag records them
// only while the link enable is set. The mirror is the global flag gated by
// both enables. A PHY flag read clears both flags; a new event wins over it.
module nic_irq_phy (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_wr,
    input  logic [1:0] en_data,
    input  logic       link_evt,
    input  logic       flag_rd,
    output logic       link_flag,
    output logic       glb_flag,
    output logic [1:0] phy_en,
    output logic       mirror
);
    logic       link_q;
    logic       glb_q;
    logic [1:0] en_q;

    // Hold the PHY link enable (bit 0) and PHY global enable (bit 1).
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 2'b00;
        else if (en_wr) en_q <= en_data;
    end

    // Record link events in the PHY link flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        link_q <= 1'b0;
        else if (link_evt) link_q <= 1'b1;
        else if (flag_rd)  link_q <= 1'b0;
    end

    // Record enabled link events in the PHY global flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                  glb_q <= 1'b0;
        else if (link_evt && en_q[0]) glb_q <= 1'b1;
        else if (flag_rd)            glb_q <= 1'b0;
    end

    // Gate the global flag onto the controller-side link bit.
    always_comb mirror = glb_q & en_q[0] & en_q[1];

    assign link_flag = link_q;
    assign glb_flag  = glb_q;
    assign phy_en    = en_q;

    // R7: the mirrored bit is never seen without both PHY enables.
    assert_mirror_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mirror |-> (phy_en == 2'b11));

    // R8: a read with no concurrent event leaves both PHY flags clear.
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !link_evt) |=> (!link_flag && !glb_flag));
endmodule

// File: rtl/nic_irq_hub.sv
// Interrupt aggregator top: flags, enables, host set/clear, read port and
// the registered active-low interrupt output.
// Assumes all inputs are synchronous to clk and that event inputs are pulses.
module nic_irq_hub
    import nic_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_err_evt,
    input  logic             tx_err_evt,
    input  logic             tx_req,
    input  logic             dma_busy,
    input  logic             link_evt,
    input  logic [CNT_W-1:0] pkt_cnt,
    input  logic             host_wr,
    input  logic [1:0]       host_op,
    input  logic [7:0]       host_data,
    input  logic             phy_flag_rd,
    input  logic [1:0]       rd_sel,
    output logic [7:0]       rd_data,
    output logic             irq_n
);
    localparam logic [REG_W-1:0] EN_MASK = REG_W'(8'hBF);

    host_op_e                op;
    logic [1:0]              fell;
    logic [N_STICKY-1:0]     s_evt, s_set, s_clr, s_q;
    logic [REG_W-1:0]        en_q;
    logic [REG_W-1:0]        flags;
    logic                    link_flag, glb_flag, mirror;
    logic [1:0]              phy_en;
    logic                    irq_any;
    logic                    irq_n_q;

    assign op = host_op_e'(host_op);

    // Detect the end of a transmission (bit 0) and of a DMA run (bit 1).
    nic_irq_fall #(.N(2)) u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({dma_busy, tx_req}),
        .fell  (fell)
    );

    // Map host masks and events onto the sticky bank: rx, txerr, txdone, dma.
    always_comb begin
        s_set = '0;
        s_clr = '0;
        if (host_wr && op == OP_FLAG_SET)
            s_set = {host_data[B_DMA], host_data[B_TXDONE],
                     host_data[B_TXERR], host_data[B_RXERR]};
        if (host_wr && op == OP_FLAG_CLR)
            s_clr = {host_data[B_DMA], host_data[B_TXDONE],
                     host_data[B_TXERR], host_data[B_RXERR]};
        s_evt = {fell[1], fell[0] | tx_err_evt | s_set[1], tx_err_evt, rx_err_evt};
    end

    nic_irq_sticky #(.N(N_STICKY)) u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_set  (s_evt),
        .host_set (s_set),
        .host_clr (s_clr),
        .q        (s_q)
    );

    nic_irq_phy u_phy (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_wr     (host_wr && op == OP_PHY_EN_WR),
        .en_data   (host_data[1:0]),
        .link_evt  (link_evt),
        .flag_rd   (phy_flag_rd),
        .link_flag (link_flag),
        .glb_flag  (glb_flag),
        .phy_en    (phy_en),
        .mirror    (mirror)
    );

    // Hold the per-flag and global enables.
    always_ff @(posedge clk) begin
        if (!rst_n)                       en_q <= '0;
        else if (host_wr && op == OP_EN_WR) en_q <= host_data & EN_MASK;
    end

    // Assemble the flag register from sticky, mirrored and level bits.
    always_comb begin
        flags           = '0;
        flags[B_RXERR]  = s_q[0];
        flags[B_TXERR]  = s_q[1];
        flags[B_TXDONE] = s_q[2];
        flags[B_LINK]   = mirror;
        flags[B_DMA]    = s_q[3];
        flags[B_PKT]    = (pkt_cnt != '0);
    end

    // Combine enabled flags under the global enable.
    always_comb irq_any = en_q[B_GLBEN] && ((flags[5:0] & en_q[5:0]) != 6'd0);

    // Register the interrupt output so it never glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n_q <= 1'b1;
        else        irq_n_q <= ~irq_any;
    end

    assign irq_n = irq_n_q;

    // Select the register returned on the read port.
    always_comb begin
        case (rd_sel_e'(rd_sel))
            RD_FLAGS:   rd_data = flags;
            RD_ENABLES: rd_data = en_q;
            RD_STATUS:  rd_data = {7'd0, ~irq_n_q};
            default:    rd_data = {6'd0, glb_flag, link_flag};
        endcase
    end

    // R2: the output is only asserted after the global enable was set.
    assert_needs_global_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> $past(en_q[B_GLBEN]));

    // R4: end of transmit request raises transmit done.
    assert_tx_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_req) |=> flags[B_TXDONE]);

    // R5: transmit error never rises without transmit done.
    assert_txerr_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[B_TXERR]) |-> flags[B_TXDONE]);

    // R6: end of DMA raises DMA done.
    assert_dma_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_busy) |=> flags[B_DMA]);
endmodule

// File: tb/nic_irq_hub_tb.sv
module nic_irq_hub_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_err_evt = 1'b0, tx_err_evt = 1'b0, tx_req = 1'b0;
    logic       dma_busy = 1'b0, link_evt = 1'b0, phy_flag_rd = 1'b0;
    logic [7:0] pkt_cnt = 8'd0;
    logic       host_wr = 1'b0;
    logic [1:0] host_op = 2'd0;
    logic [7:0] host_data = 8'd0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       irq_n;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    nic_irq_hub u_dut (
        .clk(clk), .rst_n(rst_n), .rx_err_evt(rx_err_evt), .tx_err_evt(tx_err_evt),
        .tx_req(tx_req), .dma_busy(dma_busy), .link_evt(link_evt), .pkt_cnt(pkt_cnt),
        .host_wr(host_wr), .host_op(host_op), .host_data(host_data),
        .phy_flag_rd(phy_flag_rd), .rd_sel(rd_sel), .rd_data(rd_data), .irq_n(irq_n)
    );

    // {rx_evt, wr, op[1:0], data[7:0], exp_flags[7:0], exp_irq_n}
    localparam int NV = 12;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 1'b1, 2'd1, 8'h01, 8'h01, 1'b1},
        {1'b0, 1'b1, 2'd0, 8'h81, 8'h01, 1'b0},
        {1'b0, 1'b1, 2'd2, 8'h01, 8'h00, 1'b1},
        {1'b1, 1'b0, 2'd0, 8'h00, 8'h01, 1'b0},
        {1'b0, 1'b1, 2'd1, 8'h02, 8'h07, 1'b0},
        {1'b0, 1'b1, 2'd0, 8'h80, 8'h07, 1'b1},
        {1'b0, 1'b1, 2'd0, 8'h04, 8'h07, 1'b1},
        {1'b0, 1'b1, 2'd0, 8'h84, 8'h07, 1'b0},
        {1'b0, 1'b1, 2'd2, 8'hFF, 8'h00, 1'b1},
        {1'b0, 1'b1, 2'd1, 8'h38, 8'h10, 1'b1},
        {1'b1, 1'b1, 2'd2, 8'h11, 8'h01, 1'b1},
        {1'b0, 1'b1, 2'd2, 8'h01, 8'h00, 1'b1}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] sel, input string req, input logic [7:0] exp);
        rd_sel = sel;
        #1;
        check(req, rd_data, exp);
    endtask

    // One host write: driven after a falling edge, released at the next one.
    task automatic host(input logic [1:0] op, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_op = op; host_data = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    initial begin
        #4_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        rd(2'd0, "R1 reset flags", 8'h00);
        rd(2'd1, "R1 reset enables", 8'h00);
        rd(2'd3, "R1 reset phy flags", 8'h00);
        check("R1 reset irq_n", {7'd0, irq_n}, 8'h01);
        rd(2'd2, "R11 reset status", 8'h00);
        rst_n = 1'b1;

        // Vector walk: R1 R2 R5 R10
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            rx_err_evt = VEC[i][20];
            host_wr    = VEC[i][19];
            host_op    = VEC[i][18:17];
            host_data  = VEC[i][16:9];
            @(negedge clk);
            rx_err_evt = 1'b0; host_wr = 1'b0;
            rd(2'd0, "R1 R5 R10 vector flags", VEC[i][8:1]);
            @(negedge clk);
            check("R2 vector irq_n", {7'd0, irq_n}, {7'd0, VEC[i][0]});
        end

        // R11 status bit follows the output
        host(2'd0, 8'h81);
        host(2'd1, 8'h01);
        @(negedge clk);
        check("R11 irq_n low", {7'd0, irq_n}, 8'h00);
        rd(2'd2, "R11 status active", 8'h01);
        rd(2'd1, "R12 enable readback", 8'h81);
        host(2'd2, 8'hFF);
        @(negedge clk);
        rd(2'd2, "R11 status idle", 8'h00);

        // R3 packet pending follows the count
        host(2'd0, 8'hA0);
        @(negedge clk);
        pkt_cnt = 8'd3;
        rd(2'd0, "R3 pending same cycle", 8'h20);
        @(negedge clk);
        check("R3 pending irq", {7'd0, irq_n}, 8'h00);
        host(2'd2, 8'h20);
        rd(2'd0, "R3 clear ignored", 8'h20);
        pkt_cnt = 8'd0;
        rd(2'd0, "R3 pending drops", 8'h00);
        @(negedge clk);
        check("R3 irq released", {7'd0, irq_n}, 8'h01);

        // R4 transmit request falling edge
        host(2'd0, 8'h84);
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk);
        rd(2'd0, "R4 no flag while busy", 8'h00);
        tx_req = 1'b0;
        @(negedge clk);
        rd(2'd0, "R4 tx done set", 8'h04);
        @(negedge clk);
        check("R4 tx done irq", {7'd0, irq_n}, 8'h00);
        host(2'd2, 8'hFF);

        // R5 transmit error event also raises transmit done
        @(negedge clk); tx_err_evt = 1'b1;
        @(negedge clk); tx_err_evt = 1'b0;
        rd(2'd0, "R5 error with done", 8'h06);
        host(2'd2, 8'hFF);

        // R6 DMA falling edge
        @(negedge clk); dma_busy = 1'b1;
        @(negedge clk);
        rd(2'd0, "R6 no flag while busy", 8'h00);
        dma_busy = 1'b0;
        @(negedge clk);
        rd(2'd0, "R6 dma done set", 8'h10);
        host(2'd2, 8'hFF);

        // R7 link path without PHY enables
        @(negedge clk); link_evt = 1'b1;
        @(negedge clk); link_evt = 1'b0;
        rd(2'd3, "R7 phy link flag only", 8'h01);
        rd(2'd0, "R7 link bit gated", 8'h00);
        @(negedge clk); phy_flag_rd = 1'b1;
        @(negedge clk); phy_flag_rd = 1'b0;
        rd(2'd3, "R8 phy flags cleared", 8'h00);

        // R7 R9 link path with all enables
        host(2'd3, 8'h03);
        @(negedge clk); link_evt = 1'b1;
        @(negedge clk); link_evt = 1'b0;
        rd(2'd3, "R7 both phy flags", 8'h03);
        rd(2'd0, "R7 link bit mirrored", 8'h08);
        host(2'd2, 8'h08);
        rd(2'd0, "R7 host clear ignored", 8'h08);
        host(2'd0, 8'h88);
        @(negedge clk);
        check("R9 link irq", {7'd0, irq_n}, 8'h00);
        host(2'd3, 8'h01);
        rd(2'd0, "R9 mirror off", 8'h00);
        @(negedge clk);
        check("R9 irq released", {7'd0, irq_n}, 8'h01);
        host(2'd3, 8'h03);
        rd(2'd0, "R7 mirror back", 8'h08);
        @(negedge clk); phy_flag_rd = 1'b1;
        @(negedge clk); phy_flag_rd = 1'b0;
        rd(2'd0, "R8 link bit cleared", 8'h00);
        rd(2'd3, "R8 phy flags cleared", 8'h00);
        @(negedge clk);
        check("R8 irq idle", {7'd0, irq_n}, 8'h01);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule